// File: doc/BRIEF.md
# Packed SIMD Saturating Lane ALU

This block is a 64-bit packed-data arithmetic unit. A single format bit makes it treat both operands either as eight unsigned byte lanes or as four signed halfword lanes. Every lane applies the same operation independently. The available operations are:

- bitwise logic
- left and right shifts
- saturating add, subtract and multiply
- minimum and maximum
- a halfword sign-transfer
- a byte absolute difference
- a byte rounded average

The first operand is always a full vector. The second operand is chosen by the select bits of the control field from one of three sources:

- the full second vector, lane by lane;
- one lane of the second vector, copied into every lane;
- a small zero-extended immediate, copied into every lane.

The surrounding pipeline supplies decoded operands and a 4-bit opcode. It receives the packed result one clock later, together with a flag. The flag marks an opcode that is not defined for the chosen format; for such an opcode the result is forced to zero.

Top module: `simd_lane_alu`

## Requirements
- R1: Control field bit 0 picks the lane format: 0 gives eight unsigned 8-bit lanes and 1 gives four signed 16-bit lanes. Comparisons follow that signedness, so 0x8000 is below 0x0001 in halfword min, while byte 0x80 is above 0x01.
- R2: Control field bits [4:3] pick the second-operand source: 0x means broadcast one element of op_b, 10 means the full op_b vector, and 11 means the 5-bit immediate zero-extended to the lane width and broadcast. The immediate has no effect unless bits [4:3] are 11.
- R3: For element broadcast, control bits [3:1] give the byte lane index and control bits [3:2] give the halfword lane index. Lane n occupies bits [8n+7:8n] for bytes and [16n+15:16n] for halfwords.
- R4: Add, subtract and multiply saturate. Byte lanes clamp to 0..255, and a byte subtract that would go negative gives 0. Halfword lanes clamp to -32768..32767.
- R5: Opcodes 0 to 3 are bitwise AND, NOR, OR and XOR of each lane pair.
- R6: Opcodes 4 and 5 are logical left and logical right shifts. Opcode 12 is an arithmetic right shift that exists only for halfwords. The shift count is the low 3 bits of the second operand for bytes and its low 4 bits for halfwords.
- R7: Opcode 11, a halfword-only sign transfer, gives the negated second operand when the first operand is negative, 0 when the first operand is zero, and the second operand otherwise. Negating -32768 gives 32767.
- R8: Opcode 13 is the byte absolute difference |a-b|, and opcode 14 is the byte rounded average (a+b+1)>>1. Both exist only for bytes.
- R9: Opcodes 7, 8, 9 and 10 are subtract, min, max and multiply, and opcode 6 is add, in both formats.
- R10: Opcodes 11, 12 and 15 with bytes, and opcodes 13, 14 and 15 with halfwords, set illegal_op and force a zero result. Every other opcode clears illegal_op.
- R11: Result and flag are registered: they show the inputs sampled at the previous rising edge, and a synchronous active-high reset clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed vector (source for vector and element modes) |
| imm | input | 5 | Immediate for broadcast mode |
| fmt_sel | input | 5 | Format bit 0, element index bits [3:1], source bits [4:3] |
| opcode | input | 4 | Lane operation, 0 to 15 |
| result | output | 64 | Registered packed result |
| illegal_op | output | 1 | Registered flag: opcode undefined for the format |

## Verification
The bench builds the block with its defaults: a 64-bit datapath and a 5-bit immediate. With these values all eight byte lanes and all four halfword lanes are visible, and every element index that the select field can encode is in reach. A 5-bit immediate reaches 31 in a halfword lane, which is enough to push 0x7FF0 into positive saturation. The same value shows that the immediate is zero-extended rather than sign-extended, and its bit 4 shows that halfword shift counts are masked to 4 bits.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_NOR  = 4'd1,
    OP_OR   = 4'd2,
    OP_XOR  = 4'd3,
    OP_SLL  = 4'd4,
    OP_SRL  = 4'd5,
    OP_ADD  = 4'd6,
    OP_SUB  = 4'd7,
    OP_MIN  = 4'd8,
    OP_MAX  = 4'd9,
    OP_MUL  = 4'd10,
    OP_MSGN = 4'd11,
    OP_SRA  = 4'd12,
    OP_ABSD = 4'd13,
    OP_AVG  = 4'd14,
    OP_RSVD = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_ELEM = 2'd0,
    SRC_VECT = 2'd1,
    SRC_IMM  = 2'd2
  } src_e;

  // Select bits [4:3] of the control field: 0x element, 10 vector, 11 immediate.
  function automatic src_e decode_src(input logic [1:0] sel_hi);
    if (!sel_hi[1])     return SRC_ELEM;
    else if (sel_hi[0]) return SRC_IMM;
    else                return SRC_VECT;
  endfunction

  // An opcode is usable only if the chosen format defines it.
  function automatic logic op_is_legal(input logic half_fmt, input alu_op_e op);
    if (op == OP_RSVD) return 1'b0;
    if (half_fmt)      return !(op == OP_ABSD || op == OP_AVG);
    return !(op == OP_MSGN || op == OP_SRA);
  endfunction

endpackage

// File: rtl/simd_operand_sel.sv
module simd_operand_sel
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 5
) (
  input  logic [DATA_W-1:0] op_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic [4:1]        sel,
  output logic [DATA_W-1:0] b_bytes,
  output logic [DATA_W-1:0] b_halves
);
  localparam int NB = DATA_W / BYTE_W;
  localparam int NH = DATA_W / HALF_W;

  logic [BYTE_W-1:0] byte_elem, byte_imm;
  logic [HALF_W-1:0] half_elem, half_imm;
  src_e              src;

  always_comb begin
    byte_elem = op_b[int'(sel[3:1])*BYTE_W +: BYTE_W];
    half_elem = op_b[int'(sel[3:2])*HALF_W +: HALF_W];
    byte_imm  = {{(BYTE_W-IMM_W){1'b0}}, imm};
    half_imm  = {{(HALF_W-IMM_W){1'b0}}, imm};
    src       = decode_src(sel[4:3]);
    unique case (src)
      SRC_VECT: begin
        b_bytes  = op_b;
        b_halves = op_b;
      end
      SRC_IMM: begin
        b_bytes  = {NB{byte_imm}};
        b_halves = {NH{half_imm}};
      end
      default: begin
        b_bytes  = {NB{byte_elem}};
        b_halves = {NH{half_elem}};
      end
    endcase
  end

endmodule

// File: rtl/simd_byte_lane.sv
module simd_byte_lane
  import simd_alu_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  input  alu_op_e           op,
  output logic [BYTE_W-1:0] y
);
  logic [BYTE_W:0]     sum_w, avg_w;
  logic [2*BYTE_W-1:0] prod_w;

  always_comb begin
    sum_w  = {1'b0, a} + {1'b0, b};
    avg_w  = sum_w + {{BYTE_W{1'b0}}, 1'b1};
    prod_w = {{BYTE_W{1'b0}}, a} * {{BYTE_W{1'b0}}, b};
    unique case (op)
      OP_AND:  y = a & b;
      OP_NOR:  y = ~(a | b);
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SLL:  y = a << b[2:0];
      OP_SRL:  y = a >> b[2:0];
      OP_ADD:  y = sum_w[BYTE_W] ? {BYTE_W{1'b1}} : sum_w[BYTE_W-1:0];
      OP_SUB:  y = (a < b) ? '0 : a - b;
      OP_MIN:  y = (a < b) ? a : b;
      OP_MAX:  y = (a > b) ? a : b;
      OP_MUL:  y = (|prod_w[2*BYTE_W-1:BYTE_W]) ? {BYTE_W{1'b1}} : prod_w[BYTE_W-1:0];
      OP_ABSD: y = (a >= b) ? a - b : b - a;
      OP_AVG:  y = avg_w[BYTE_W:1];
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/simd_half_lane.sv
module simd_half_lane
  import simd_alu_pkg::*;
(
  input  logic [HALF_W-1:0] a,
  input  logic [HALF_W-1:0] b,
  input  alu_op_e           op,
  output logic [HALF_W-1:0] y
);
  localparam int WIDE_W = 2 * HALF_W;
  localparam logic signed [WIDE_W-1:0] MAX_V = WIDE_W'(32767);
  localparam logic signed [WIDE_W-1:0] MIN_V = -WIDE_W'(32768);

  function automatic logic [HALF_W-1:0] clamp(input logic signed [WIDE_W-1:0] v);
    if (v > MAX_V)      return 16'h7FFF;
    else if (v < MIN_V) return 16'h8000;
    else                return v[HALF_W-1:0];
  endfunction

  logic signed [HALF_W-1:0] as, bs;
  logic signed [WIDE_W-1:0] aw, bw;

  always_comb begin
    as = $signed(a);
    bs = $signed(b);
    aw = WIDE_W'(as);
    bw = WIDE_W'(bs);
    unique case (op)
      OP_AND:  y = a & b;
      OP_NOR:  y = ~(a | b);
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SLL:  y = a << b[3:0];
      OP_SRL:  y = a >> b[3:0];
      OP_SRA:  y = as >>> b[3:0];
      OP_ADD:  y = clamp(aw + bw);
      OP_SUB:  y = clamp(aw - bw);
      OP_MUL:  y = clamp(aw * bw);
      OP_MIN:  y = (as < bs) ? a : b;
      OP_MAX:  y = (as > bs) ? a : b;
      OP_MSGN: begin
        if (as < 0)       y = (b == 16'h8000) ? 16'h7FFF : 16'(-bs);
        else if (a == '0) y = '0;
        else              y = b;
      end
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic [4:0]        fmt_sel,
  input  logic [3:0]        opcode,
  output logic [DATA_W-1:0] result,
  output logic              illegal_op
);
  localparam int NB = DATA_W / BYTE_W;
  localparam int NH = DATA_W / HALF_W;

  alu_op_e           op;
  logic [DATA_W-1:0] b_bytes, b_halves, byte_res, half_res;
  logic              legal;

  assign op    = alu_op_e'(opcode);
  assign legal = op_is_legal(fmt_sel[0], op);

  simd_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .op_b    (op_b),
    .imm     (imm),
    .sel     (fmt_sel[4:1]),
    .b_bytes (b_bytes),
    .b_halves(b_halves)
  );

  for (genvar i = 0; i < NB; i++) begin : g_byte
    simd_byte_lane u_lane (
      .a (op_a[i*BYTE_W +: BYTE_W]),
      .b (b_bytes[i*BYTE_W +: BYTE_W]),
      .op(op),
      .y (byte_res[i*BYTE_W +: BYTE_W])
    );
  end

  for (genvar j = 0; j < NH; j++) begin : g_half
    simd_half_lane u_lane (
      .a (op_a[j*HALF_W +: HALF_W]),
      .b (b_halves[j*HALF_W +: HALF_W]),
      .op(op),
      .y (half_res[j*HALF_W +: HALF_W])
    );
  end

  // R11: one register stage, synchronous reset
  always_ff @(posedge clk) begin
    if (rst) begin
      result     <= '0;
      illegal_op <= 1'b0;
    end else begin
      illegal_op <= !legal;
      result     <= !legal ? '0 : (fmt_sel[0] ? half_res : byte_res);
    end
  end

  // R10: a flagged opcode never leaks lane data
  a_r10_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> (result == '0));

  for (genvar i = 0; i < NB; i++) begin : g_byte_chk
    // R4: an unsigned byte subtract never exceeds its minuend
    a_r4_sub_floor: assert property (@(posedge clk) disable iff (rst)
      $past(!fmt_sel[0] && op == OP_SUB) |->
        (result[i*BYTE_W +: BYTE_W] <= $past(op_a[i*BYTE_W +: BYTE_W])));
  end

  for (genvar j = 0; j < NH; j++) begin : g_half_chk
    // R4: two non-negative halfwords never sum to a negative value
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
      $past(fmt_sel[0] && op == OP_ADD && !op_a[j*HALF_W+HALF_W-1]
            && !b_halves[j*HALF_W+HALF_W-1]) |->
        !result[j*HALF_W+HALF_W-1]);
    // R7: a zero first operand gives zero under sign transfer
    a_r7_msgn_zero: assert property (@(posedge clk) disable iff (rst)
      $past(fmt_sel[0] && op == OP_MSGN && op_a[j*HALF_W +: HALF_W] == '0) |->
        (result[j*HALF_W +: HALF_W] == '0));
  end

endmodule

// File: tb/simd_lane_alu_test.sv
module simd_lane_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op_a = '0, op_b = '0;
  logic [4:0]  imm = '0, fmt_sel = '0;
  logic [3:0]  opcode = '0;
  logic [63:0] result;
  logic        illegal_op;
  int checks = 0, errors = 0;

  localparam logic [4:0] B_VEC = 5'b10000, H_VEC = 5'b10001;
  localparam logic [4:0] B_IMM = 5'b11000, H_IMM = 5'b11001;

  always #5 clk = ~clk;

  simd_lane_alu uut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .imm(imm),
    .fmt_sel(fmt_sel), .opcode(opcode), .result(result), .illegal_op(illegal_op)
  );

  task automatic check(input string tag, input logic [63:0] exp_res, input logic exp_ill);
    checks++;
    if (result !== exp_res || illegal_op !== exp_ill) begin
      errors++;
      $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
               tag, result, illegal_op, exp_res, exp_ill);
    end
  endtask

  // Drive at a falling edge; the result is registered at the next rising edge
  // and sampled at the falling edge after it.
  task automatic run(input logic [63:0] a, input logic [63:0] b, input logic [4:0] im,
                     input logic [4:0] fs, input logic [3:0] opc,
                     input string tag, input logic [63:0] exp_res, input logic exp_ill);
    @(negedge clk);
    op_a = a; op_b = b; imm = im; fmt_sel = fs; opcode = opc;
    @(negedge clk);
    check(tag, exp_res, exp_ill);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R11 reset state", 64'h0, 1'b0);
  endtask

  task automatic t_logic;
    run(64'hF0F0_F0F0_0F0F_0F0F, 64'hFF00_FF00_FF00_FF00, 5'h15, B_VEC, 4'd0,
        "R5 and", 64'hF000_F000_0F00_0F00, 1'b0);
    run(64'hF0F0_F0F0_0F0F_0F0F, 64'hFF00_FF00_FF00_FF00, 5'h15, B_VEC, 4'd1,
        "R5 nor", 64'h000F_000F_00F0_00F0, 1'b0);
    run(64'hF0F0_F0F0_0F0F_0F0F, 64'hFF00_FF00_FF00_FF00, 5'h15, H_VEC, 4'd3,
        "R5 xor", 64'h0FF0_0FF0_F00F_F00F, 1'b0);
  endtask

  task automatic t_byte_arith;
    run(64'h80FF_0102_7F00_FE10, 64'h8001_0203_8000_0220, 5'h1F, B_VEC, 4'd6,
        "R4 R9 byte add", 64'hFFFF_0305_FF00_FF30, 1'b0);
    run(64'h80FF_0102_7F00_FE10, 64'h8001_0203_8000_0220, 5'h1F, B_VEC, 4'd7,
        "R4 R9 byte sub", 64'h00FE_0000_0000_FC00, 1'b0);
    run(64'h100F_02FF_0100_1103, 64'h1011_7F02_FF55_0F05, 5'h00, B_VEC, 4'd10,
        "R4 R9 byte mul", 64'hFFFF_FEFF_FF00_FF0F, 1'b0);
  endtask

  task automatic t_half_arith;
    run(64'h7FFF_8000_0005_FFFF, 64'h0001_FFFF_FFF0_0001, 5'h1F, H_VEC, 4'd6,
        "R4 R9 half add", 64'h7FFF_8000_FFF5_0000, 1'b0);
    run(64'h7FFF_8000_0005_FFFF, 64'h0001_FFFF_FFF0_0001, 5'h1F, H_VEC, 4'd7,
        "R4 R9 half sub", 64'h7FFE_8001_0015_FFFE, 1'b0);
    run(64'h0100_8000_FFFF_0003, 64'h0100_0002_8000_FFFB, 5'h1F, H_VEC, 4'd10,
        "R4 R9 half mul", 64'h7FFF_8000_7FFF_FFF1, 1'b0);
  endtask

  task automatic t_minmax;
    run(64'h8000_0001_FFFF_0000, 64'h0001_8000_0000_FFFF, 5'h0, H_VEC, 4'd8,
        "R1 half min signed", 64'h8000_8000_FFFF_FFFF, 1'b0);
    run(64'h8000_0001_FFFF_0000, 64'h0001_8000_0000_FFFF, 5'h0, H_VEC, 4'd9,
        "R1 half max signed", 64'h0001_0001_0000_0000, 1'b0);
    run(64'h8000_0001_FFFF_0000, 64'h0001_8000_0000_FFFF, 5'h0, B_VEC, 4'd8,
        "R1 byte min unsigned", 64'h0, 1'b0);
    run(64'h8000_0001_FFFF_0000, 64'h0001_8000_0000_FFFF, 5'h0, B_VEC, 4'd9,
        "R1 byte max unsigned", 64'h8001_8001_FFFF_FFFF, 1'b0);
  endtask

  task automatic t_shift;
    run(64'h8001_4000_0001_1234, 64'h0, 5'd17, H_IMM, 4'd4,
        "R6 half sll count masked", 64'h0002_8000_0002_2468, 1'b0);
    run(64'h8001_4000_0001_1234, 64'h0004_0010_000F_0000, 5'h0, H_VEC, 4'd5,
        "R6 half srl", 64'h0800_4000_0000_1234, 1'b0);
    run(64'h8001_4000_0001_1234, 64'h0004_0010_000F_0000, 5'h0, H_VEC, 4'd12,
        "R6 half sra", 64'hF800_4000_0000_1234, 1'b0);
    run(64'h80FF_0102_0304_0506, 64'h0, 5'd9, B_IMM, 4'd5,
        "R6 byte srl count masked", 64'h407F_0001_0102_0203, 1'b0);
    run(64'h80FF_0102_0304_0506, 64'h0108_0F07_0000_0000, 5'h0, B_VEC, 4'd4,
        "R6 byte sll", 64'h00FF_8000_0304_0506, 1'b0);
  endtask

  task automatic t_special;
    run(64'hFFFF_FFFF_0000_0005, 64'h8000_0003_1234_8000, 5'h0, H_VEC, 4'd11,
        "R7 msgn", 64'h7FFF_FFFD_0000_8000, 1'b0);
    run(64'h0010_FF00_0180_7F00, 64'h1000_00FF_8001_807F, 5'h0, B_VEC, 4'd13,
        "R8 absdiff", 64'h1010_FFFF_7F7F_017F, 1'b0);
    run(64'h0010_FF00_0180_7F00, 64'h1000_00FF_8001_807F, 5'h0, B_VEC, 4'd14,
        "R8 avg", 64'h0808_8080_4141_8040, 1'b0);
  endtask

  task automatic t_select;
    run(64'h0001_0203_04DE_F0FF, 64'h0011_2233_4455_6677, 5'h1F, 5'b01010, 4'd6,
        "R2 R3 byte element lane 5", 64'h2223_2425_26FF_FFFF, 1'b0);
    run(64'h0000_1100_0000_FFFF, 64'h0011_2233_4455_6677, 5'h1F, 5'b01001, 4'd2,
        "R2 R3 half element lane 2", 64'h2233_3333_2233_FFFF, 1'b0);
    run(64'hFFFF_0000_7FF0_8000, 64'h1234_5678_9ABC_DEF0, 5'h1F, H_IMM, 4'd6,
        "R2 half immediate zero-extended", 64'h001E_001F_7FFF_801F, 1'b0);
  endtask

  task automatic t_illegal;
    run(64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 5'h0, B_VEC, 4'd11,
        "R10 byte msgn illegal", 64'h0, 1'b1);
    run(64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 5'h0, B_VEC, 4'd12,
        "R10 byte sra illegal", 64'h0, 1'b1);
    run(64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 5'h0, H_VEC, 4'd13,
        "R10 half absdiff illegal", 64'h0, 1'b1);
    run(64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 5'h0, H_VEC, 4'd14,
        "R10 half avg illegal", 64'h0, 1'b1);
    run(64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 5'h0, B_VEC, 4'd15,
        "R10 opcode 15 illegal", 64'h0, 1'b1);
    run(64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 5'h0, H_VEC, 4'd2,
        "R10 legal op clears flag", 64'h1335_5779_9BBD_DFF1, 1'b0);
  endtask

  task automatic t_latency;
    run(64'h0F0F_0F0F_0F0F_0F0F, 64'hFFFF_FFFF_0000_0000, 5'h0, B_VEC, 4'd0,
        "R11 first value", 64'h0F0F_0F0F_0000_0000, 1'b0);
    @(negedge clk);
    opcode = 4'd2;
    #1;
    check("R11 output holds before edge", 64'h0F0F_0F0F_0000_0000, 1'b0);
    @(negedge clk);
    check("R11 output one edge later", 64'hFFFF_FFFF_0F0F_0F0F, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check("R11 synchronous reset clears", 64'h0, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: result=%h expected completion", result);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_logic();
    t_byte_arith();
    t_half_arith();
    t_minmax();
    t_shift();
    t_special();
    t_select();
    t_illegal();
    t_latency();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule